// File: doc/BRIEF.md
# Limb Comparison Witness Checker

This block audits the evidence offered for a conditional-branch comparison, without computing the comparison itself. Two operands arrive split into limbs, together with one flag per comparison kind (signed less-than, unsigned less-than, signed greater-or-equal, unsigned greater-or-equal), a claimed branch outcome and a claimed less-than bit. A witness comes with them: sign-adjusted values of both top limbs, a one-hot marker naming the most significant limb where the operands differ, and the positive magnitude of the difference at that limb.

The block is purely combinational. It raises `valid` only when every consistency rule holds, and it exposes one error bit per rule. It also produces the next program counter: the current PC plus the immediate when the branch is taken, and the current PC plus a fixed step when it is not. A witness that passes every rule pins the branch outcome to the true comparison result. A producer that computes the witness quickly can therefore be checked by a small, shallow circuit.

Top module: `branch_cmp_witness_check`

## Requirements
- R1: `valid` is high only when exactly one of the four opcode flags is set. When zero flags or several flags are set, error bit 0 is raised.
- R2: For the less-than opcodes, the claimed less-than bit must equal `br_taken`. For the greater-or-equal opcodes, it must equal the inverse of `br_taken`. A mismatch raises error bit 1.
- R3: The raw top limb of each operand, minus its signed top-limb input, must be 0 or exactly 2^LB. A violation raises error bit 2 (operand a) or error bit 3 (operand b).
- R4: Each signed top-limb input must lie in [-2^(LB-1), 2^(LB-1)) for the signed opcodes and in [0, 2^LB) for the unsigned opcodes. A violation on either operand raises error bit 4.
- R5: At most one marker bit may be set, otherwise error bit 5 is raised. Every limb above the marked limb must have equal a and b values, and with no marker every limb must be equal; the top limb compares its signed values. A nonzero difference there raises error bit 6. Bit i of the marker names limb i, and limb 0 is the least significant.
- R6: At the marked limb, `diff_val` must equal b minus a when less-than is claimed, and a minus b otherwise, using the signed values at the top limb. A mismatch raises error bit 7. A witness built this way from correct operands is accepted.
- R7: When a marker is set, `diff_val` must lie in [1, 2^LB], otherwise error bit 8 is raised. When no marker is set, a claimed less-than bit of 1 raises error bit 9.
- R8: `next_pc` is `pc + imm` when `br_taken` is 1 and `pc + STEP` when it is 0, both wrapping modulo 2^PCW.
- R9: `err` holds one bit per rule at the positions given in R1 to R7. `valid` is high exactly when `err` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_limbs | input | NL*LB | First operand, limb i at bits [i*LB +: LB] |
| b_limbs | input | NL*LB | Second operand, same layout |
| op_slt | input | 1 | Signed less-than opcode flag |
| op_ult | input | 1 | Unsigned less-than opcode flag |
| op_sge | input | 1 | Signed greater-or-equal opcode flag |
| op_uge | input | 1 | Unsigned greater-or-equal opcode flag |
| br_taken | input | 1 | Claimed branch outcome |
| lt_claim | input | 1 | Claimed a-less-than-b bit |
| a_top_s | input | LB+2 | Signed (two's complement) value of a's top limb |
| b_top_s | input | LB+2 | Signed (two's complement) value of b's top limb |
| mark | input | NL | One-hot marker of the first differing limb |
| diff_val | input | LB+2 | Claimed positive difference at the marked limb |
| pc | input | PCW | Current program counter |
| imm | input | PCW | Branch offset |
| valid | output | 1 | All consistency rules hold |
| next_pc | output | PCW | Computed next program counter |
| err | output | 10 | One failure bit per rule |

## Verification
The assertions check on every evaluation that an accepted witness always carries a single opcode flag, and that an accepted branch outcome agrees with an independent signed or unsigned comparison of the full operands. They also check that an accepted witness has a marker exactly when the operands differ, and that `valid` and the error vector agree. Only the bench scenarios show that each rule fires on its own kind of corruption: a wrong lift, an out-of-range top limb, a marker placed too low, doubled markers, a zero difference, and a mismatched difference. The same holds for PC wrap-around on both the taken and not-taken paths.

// File: rtl/branch_cmp_witness_check.sv
module branch_cmp_witness_check #(
  parameter int NL   = 4,
  parameter int LB   = 8,
  parameter int PCW  = 32,
  parameter int STEP = 4
) (
  input  logic [NL*LB-1:0]        a_limbs,
  input  logic [NL*LB-1:0]        b_limbs,
  input  logic                    op_slt,
  input  logic                    op_ult,
  input  logic                    op_sge,
  input  logic                    op_uge,
  input  logic                    br_taken,
  input  logic                    lt_claim,
  input  logic signed [LB+1:0]    a_top_s,
  input  logic signed [LB+1:0]    b_top_s,
  input  logic [NL-1:0]           mark,
  input  logic [LB+1:0]           diff_val,
  input  logic [PCW-1:0]          pc,
  input  logic [PCW-1:0]          imm,
  output logic                    valid,
  output logic [PCW-1:0]          next_pc,
  output logic [9:0]              err
);
  localparam int DW    = LB + 4;
  localparam int TOPLO = (NL - 1) * LB;
  localparam int FULL  = 1 << LB;
  localparam int HALF  = 1 << (LB - 1);

  logic signed [DW-1:0] a_top_x, b_top_x, a_raw_x, b_raw_x, lift_a, lift_b;
  logic signed [DW-1:0] d  [NL];
  logic signed [DW-1:0] od [NL];
  logic signed [DW-1:0] sel_diff;
  logic [NL-1:0]        above_bad;
  logic                 signed_op, marked, lt_ok, rng_a, rng_b;

  assign signed_op = op_slt | op_sge;
  assign marked    = |mark;

  assign a_top_x = DW'(a_top_s);
  assign b_top_x = DW'(b_top_s);
  assign a_raw_x = $signed({{(DW-LB){1'b0}}, a_limbs[TOPLO +: LB]});
  assign b_raw_x = $signed({{(DW-LB){1'b0}}, b_limbs[TOPLO +: LB]});
  assign lift_a  = a_raw_x - a_top_x;
  assign lift_b  = b_raw_x - b_top_x;

  for (genvar i = 0; i < NL; i++) begin : g_limb
    logic signed [DW-1:0] ai, bi;
    if (i == NL - 1) begin : g_top
      assign ai = a_top_x;
      assign bi = b_top_x;
    end else begin : g_low
      assign ai = $signed({{(DW-LB){1'b0}}, a_limbs[i*LB +: LB]});
      assign bi = $signed({{(DW-LB){1'b0}}, b_limbs[i*LB +: LB]});
    end
    assign d[i]         = bi - ai;
    assign od[i]        = lt_claim ? d[i] : -d[i];
    assign above_bad[i] = !(|mark[NL-1:i]) && (d[i] != '0);
  end

  always_comb begin
    sel_diff = '0;
    for (int i = 0; i < NL; i++)
      if (mark[i]) sel_diff = sel_diff | od[i];
  end

  always_comb begin
    if (op_slt | op_ult)      lt_ok = (lt_claim == br_taken);
    else if (op_sge | op_uge) lt_ok = (lt_claim == !br_taken);
    else                      lt_ok = 1'b1;
  end

  assign rng_a = signed_op ? (a_top_x >= -DW'(HALF) && a_top_x < DW'(HALF))
                           : (!a_top_x[DW-1] && a_top_x < DW'(FULL));
  assign rng_b = signed_op ? (b_top_x >= -DW'(HALF) && b_top_x < DW'(HALF))
                           : (!b_top_x[DW-1] && b_top_x < DW'(FULL));

  assign err[0] = ($countones({op_slt, op_ult, op_sge, op_uge}) != 1);
  assign err[1] = !lt_ok;
  assign err[2] = (lift_a != '0) && (lift_a != DW'(FULL));
  assign err[3] = (lift_b != '0) && (lift_b != DW'(FULL));
  assign err[4] = !(rng_a && rng_b);
  assign err[5] = ($countones(mark) > 1);
  assign err[6] = |above_bad;
  assign err[7] = marked && ($signed({2'b00, diff_val}) != sel_diff);
  assign err[8] = marked && (diff_val == '0 || diff_val > (LB+2)'(FULL));
  assign err[9] = !marked && lt_claim;

  assign valid   = (err == '0);
  assign next_pc = pc + (br_taken ? imm : PCW'(STEP));
endmodule

module branch_cmp_witness_sva #(
  parameter int NL = 4,
  parameter int LB = 8
) (
  input logic [NL*LB-1:0] a_limbs,
  input logic [NL*LB-1:0] b_limbs,
  input logic             op_slt,
  input logic             op_ult,
  input logic             op_sge,
  input logic             op_uge,
  input logic             br_taken,
  input logic             lt_claim,
  input logic [NL-1:0]    mark,
  input logic             valid,
  input logic [9:0]       err
);
  logic lt_true, want_br;
  assign lt_true = (op_slt | op_sge) ? ($signed(a_limbs) < $signed(b_limbs)) : (a_limbs < b_limbs);
  assign want_br = (op_sge | op_uge) ? !lt_true : lt_true;

  always_comb begin
    if (!$isunknown({a_limbs, b_limbs, op_slt, op_ult, op_sge, op_uge,
                     br_taken, lt_claim, mark, valid, err})) begin
      p_one_flag_r1: assert (!valid || $onehot({op_slt, op_ult, op_sge, op_uge}))
        else $error("accepted witness without a single opcode flag");
      p_lt_link_r2: assert (!(valid && (op_slt | op_ult)) || (lt_claim == br_taken))
        else $error("accepted less-than claim disagrees with branch");
      p_mark_iff_diff_r5: assert (!valid || ((mark == '0) == (a_limbs == b_limbs)))
        else $error("accepted marker presence disagrees with operand equality");
      p_sound_r6: assert (!valid || (br_taken == want_br))
        else $error("accepted branch outcome is not the true comparison");
      p_no_mark_lt_r7: assert (!(valid && mark == '0) || !lt_claim)
        else $error("accepted less-than with no marker");
      p_err_agree_r9: assert (valid == (err == '0))
        else $error("valid and error vector disagree");
    end
  end
endmodule

bind branch_cmp_witness_check branch_cmp_witness_sva #(.NL(NL), .LB(LB)) u_sva (
  .a_limbs(a_limbs), .b_limbs(b_limbs), .op_slt(op_slt), .op_ult(op_ult),
  .op_sge(op_sge), .op_uge(op_uge), .br_taken(br_taken), .lt_claim(lt_claim),
  .mark(mark), .valid(valid), .err(err)
);

// File: tb/test_branch_cmp_witness_check.sv
module test_branch_cmp_witness_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0]       a_limbs, b_limbs, pc, imm, next_pc;
  logic              op_slt, op_ult, op_sge, op_uge, br_taken, lt_claim, valid;
  logic signed [9:0] a_top_s, b_top_s;
  logic [3:0]        mark;
  logic [9:0]        diff_val, err;
  int nchecks = 0;
  int nerr = 0;
  bit exp_br;

  branch_cmp_witness_check i_branch_cmp_witness_check (
    .a_limbs(a_limbs), .b_limbs(b_limbs), .op_slt(op_slt), .op_ult(op_ult),
    .op_sge(op_sge), .op_uge(op_uge), .br_taken(br_taken), .lt_claim(lt_claim),
    .a_top_s(a_top_s), .b_top_s(b_top_s), .mark(mark), .diff_val(diff_val),
    .pc(pc), .imm(imm), .valid(valid), .next_pc(next_pc), .err(err)
  );

  // op code: 0 signed lt, 1 unsigned lt, 2 signed ge, 3 unsigned ge
  localparam logic [65:0] VEC [11] = '{
    {2'd0, 32'hFFFFFFFF, 32'h00000001},
    {2'd1, 32'hFFFFFFFF, 32'h00000001},
    {2'd2, 32'h80000000, 32'h7FFFFFFF},
    {2'd3, 32'h80000000, 32'h7FFFFFFF},
    {2'd0, 32'h12345678, 32'h12345678},
    {2'd2, 32'h12345678, 32'h12345678},
    {2'd1, 32'h12345600, 32'h12345601},
    {2'd0, 32'h12FF0000, 32'h13000000},
    {2'd3, 32'h00000000, 32'hFFFFFFFF},
    {2'd0, 32'h80000000, 32'h80000001},
    {2'd0, 32'hFE000000, 32'h01000000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_err(input int bitn, input string req);
    chk(!valid && err[bitn], req, {53'd0, valid, err}, 64'(1) << bitn);
  endtask

  task automatic load(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    bit sg, ge, lt;
    int at, bt, idx, dv;
    sg = (op == 2'd0) || (op == 2'd2);
    ge = op[1];
    lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    at = int'(a[31:24]);
    bt = int'(b[31:24]);
    if (sg && a[31]) at -= 256;
    if (sg && b[31]) bt -= 256;
    idx = -1;
    for (int i = 3; i >= 0; i--)
      if (idx < 0 && a[i*8 +: 8] != b[i*8 +: 8]) idx = i;
    if (idx == 3) dv = lt ? bt - at : at - bt;
    else if (idx >= 0) dv = lt ? int'(b[idx*8 +: 8]) - int'(a[idx*8 +: 8])
                               : int'(a[idx*8 +: 8]) - int'(b[idx*8 +: 8]);
    else dv = 0;
    {op_slt, op_ult, op_sge, op_uge} = {op == 2'd0, op == 2'd1, op == 2'd2, op == 2'd3};
    a_limbs = a; b_limbs = b;
    a_top_s = 10'(at); b_top_s = 10'(bt);
    mark = (idx < 0) ? 4'd0 : 4'(1 << idx);
    diff_val = 10'(dv);
    lt_claim = lt;
    br_taken = lt ^ ge;
    exp_br = lt ^ ge;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    {a_limbs, b_limbs, op_slt, op_ult, op_sge, op_uge, br_taken, lt_claim} = '0;
    {a_top_s, b_top_s, mark, diff_val, pc, imm} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!valid && err[0], "R1 idle no opcode", {53'd0, valid, err}, 64'd1);
    chk(next_pc == 32'd4, "R8 idle pc", next_pc, 4);

    pc = 32'h1000; imm = 32'h40;
    for (int v = 0; v < 11; v++) begin
      @(negedge clk);
      load(VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
      #1;
      chk(valid && err == '0, "R6 R9 correct witness accepted", {53'd0, valid, err}, 64'h400);
      chk(next_pc == (exp_br ? 32'h1040 : 32'h1004), "R8 next pc", next_pc, exp_br ? 32'h1040 : 32'h1004);
    end

    @(negedge clk); load(2'd0, 1, 2); op_ult = 1'b1; #1;
    chk_err(0, "R1 two flags");
    @(negedge clk); load(2'd1, 5, 9); lt_claim = ~lt_claim; #1;
    chk_err(1, "R2 lt link broken");
    @(negedge clk); load(2'd0, 32'hFF000000, 1); a_top_s = a_top_s + 10'sd1; #1;
    chk_err(2, "R3 bad lift a");
    @(negedge clk); load(2'd1, 7, 32'h05000000); b_top_s = b_top_s - 10'sd3; #1;
    chk_err(3, "R3 bad lift b");
    @(negedge clk); load(2'd0, 1, 32'h80000000); b_top_s = b_top_s + 10'sd256; #1;
    chk(!valid && err[4] && !err[3], "R4 signed range", {53'd0, valid, err}, 64'h10);
    @(negedge clk); load(2'd1, 32'hF0000000, 0); a_top_s = -10'sd16; #1;
    chk(!valid && err[4] && !err[2], "R4 unsigned range", {53'd0, valid, err}, 64'h10);
    @(negedge clk); load(2'd1, 32'h100, 32'h200); mark = 4'b0011; #1;
    chk_err(5, "R5 two markers");
    @(negedge clk); load(2'd1, 32'h01000001, 32'h02000002); mark = 4'b0001; diff_val = 10'd1; #1;
    chk_err(6, "R5 marker too low");
    @(negedge clk); load(2'd3, 32'h500, 32'h300); diff_val = diff_val + 10'd1; #1;
    chk_err(7, "R6 diff mismatch");
    @(negedge clk); load(2'd1, 7, 7); mark = 4'b0001; diff_val = 10'd0; #1;
    chk(!valid && err[8] && !err[7], "R7 zero difference", {53'd0, valid, err}, 64'h100);
    @(negedge clk); load(2'd0, 7, 7); lt_claim = 1'b1; br_taken = 1'b1; #1;
    chk(!valid && err[9] && !err[1], "R7 lt without marker", {53'd0, valid, err}, 64'h200);

    @(negedge clk); load(2'd1, 0, 1); pc = 32'hFFFFFFF0; imm = 32'h20; #1;
    chk(next_pc == 32'h10, "R8 taken wrap", next_pc, 32'h10);
    @(negedge clk); load(2'd1, 1, 0); pc = 32'hFFFFFFFC; #1;
    chk(next_pc == 32'h0, "R8 not-taken wrap", next_pc, 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule